// File: doc/BRIEF.md
# Periodic Refresh Request Timer

This block tells a DRAM controller when to run a refresh cycle. The system clock passes through two power-of-two dividers: a selectable prescaler and a coarse system divider. Their combined output pulse advances an 8-bit period counter. Each time that counter wraps, the timer raises a refresh request for one memory bank. The banks are taken in turn, from a configurable count of one to eight. Software chooses the period value so that the request rate, divided among the banks, still reaches every bank within its retention window. For example, a 25 MHz clock, 15.6 retention units, a prescaler of 32, a unit divider and a single bank give a period of 12.

All configuration is captured by a single load strobe. A load restarts both counters and the bank rotation. The controller answers each request with an acknowledge. If a new expiry arrives while the previous request is still unanswered, the timer raises a sticky missed-refresh flag. The expiry is not dropped silently.

Top module: `rfsh_timer`

## Requirements
- R1: After reset, `req_o` is 0, `miss_o` is 0 and `req_cs_o` is 0.
- R2: With enable set, the first request rises exactly D*P clock cycles after the clock edge that captures `cfg_load_i`. Here D = 2^(min(presc,5)+1) * 4^div and P is the period value.
- R3: A period value of 0 counts as 256 prescaled ticks.
- R4: With enable captured as 0, `req_o` never asserts.
- R5: A request stays asserted with a stable `req_cs_o` until it is acknowledged. The edge that sees `ack_i` high with `req_o` high clears it. `ack_i` while no request is pending has no effect.
- R6: The bank field holds the bank count minus one (0 to 7 means 1 to 8 banks). Successive issued requests carry bank indices 0, 1, ..., count-1 and then 0 again.
- R7: An expiry that finds a pending request with `ack_i` low sets `miss_o`. `miss_o` stays set until the next load. The pending request and its bank are kept, and the rotation does not advance. An expiry in the same cycle as an acknowledge issues the next request at once.
- R8: A load restarts the prescaler and the period counter from zero, drops any pending request, clears `miss_o` and restarts the rotation at bank 0.
- R9: Prescaler select values 5, 6 and 7 all divide by 64. Select s below 5 divides by 2^(s+1).
- R10: Expiries repeat every D*P cycles, whatever the handshake timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Captures all cfg_* inputs and restarts the timer |
| cfg_enable_i | input | 1 | Allows requests when 1 |
| cfg_period_i | input | 8 | Prescaled ticks between expiries (0 means 256) |
| cfg_presc_i | input | 3 | Prescaler select, divide by 2^(min(s,5)+1) |
| cfg_div_i | input | 2 | System divider select, divide by 4^v |
| cfg_banks_i | input | 3 | Number of banks served minus one |
| ack_i | input | 1 | Controller accepted the pending request |
| req_o | output | 1 | Refresh request pending |
| req_cs_o | output | 3 | Bank index of the pending request |
| miss_o | output | 1 | Sticky flag: an expiry found a request still pending |

## Verification
The hardest situation to reach is an expiry that lands in the same clock cycle as an acknowledge, or one cycle either side of it. That single cycle decides between a back-to-back issue and a missed refresh. The bench reaches it with a tiny divide of 2 and a period of 3. It counts cycles from the load edge and raises `ack_i` exactly in the cycle before the second expiry edge. It also withholds the acknowledge across a whole period to force the missed case. Random prescaler, divider, period and bank counts then cover the timing formula and the rotation wrap.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    localparam int PERIOD_W = 8;
    localparam int BANK_W   = 3;
    localparam int PSEL_W   = 3;
    localparam int PEXP_MAX = 6;
    localparam int DIV_W    = 2;
    localparam int DEXP_MAX = 2 * ((1 << DIV_W) - 1);
    localparam int TICK_W   = PEXP_MAX + DEXP_MAX;
    localparam int EXP_W    = $clog2(TICK_W + 1);

    typedef struct packed {
        logic                enable;
        logic [PERIOD_W-1:0] period;
        logic [PSEL_W-1:0]   presc;
        logic [DIV_W-1:0]    div;
        logic [BANK_W-1:0]   banks;
    } rfsh_cfg_t;

    typedef struct packed {
        logic              req;
        logic              miss;
        logic [BANK_W-1:0] cs;
        logic [BANK_W-1:0] nxt;
    } rfsh_rot_t;
endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
    parameter int TICK_W = rfsh_pkg::TICK_W,
    parameter int EXP_W  = rfsh_pkg::EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [TICK_W-1:0] cnt;
    } pre_t;

    pre_t              s_d, s_q;
    logic [TICK_W-1:0] term;

    always_comb begin
        term   = ~({TICK_W{1'b1}} << exp_i);
        tick_o = run_i && (s_q.cnt == term);
        s_d    = s_q;
        if (restart_i || !run_i || tick_o) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && !restart_i |=> !tick_o);
endmodule

// File: rtl/rfsh_period.sv
module rfsh_period #(
    parameter int PERIOD_W = rfsh_pkg::PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart_i,
    input  logic                run_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                expire_o
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } per_t;

    per_t                s_d, s_q;
    logic [PERIOD_W-1:0] last;

    always_comb begin
        last     = (period_i == '0) ? {PERIOD_W{1'b1}} : period_i - 1'b1;
        expire_o = run_i && tick_i && (s_q.cnt == last);
        s_d      = s_q;
        if (restart_i || !run_i || expire_o) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> s_q.cnt <= last);
endmodule

// File: rtl/rfsh_rotator.sv
module rfsh_rotator #(
    parameter int BANK_W = rfsh_pkg::BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              expire_i,
    input  logic              ack_i,
    input  logic [BANK_W-1:0] banks_i,
    output logic              req_o,
    output logic [BANK_W-1:0] cs_o,
    output logic              miss_o
);
    import rfsh_pkg::*;

    rfsh_rot_t         s_d, s_q;
    logic [BANK_W-1:0] ptr;
    logic              slot_free;

    always_comb begin
        ptr       = (s_q.nxt > banks_i) ? '0 : s_q.nxt;
        slot_free = !s_q.req || ack_i;
        s_d       = s_q;
        if (s_q.req && ack_i) s_d.req = 1'b0;
        if (expire_i) begin
            if (slot_free) begin
                s_d.req = 1'b1;
                s_d.cs  = ptr;
                s_d.nxt = (ptr == banks_i) ? '0 : ptr + 1'b1;
            end else begin
                s_d.miss = 1'b1;
            end
        end
        if (restart_i) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_o  = s_q.req;
    assign cs_o   = s_q.cs;
    assign miss_o = s_q.miss;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req && !ack_i && !restart_i |=> s_q.req);

    // R5
    cs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req && !ack_i && !restart_i |=> $stable(s_q.cs));

    // R6
    cs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req |-> s_q.cs <= banks_i);

    // R7
    miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.miss && !restart_i |=> s_q.miss);
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int PERIOD_W = rfsh_pkg::PERIOD_W,
    parameter int BANK_W   = rfsh_pkg::BANK_W,
    parameter int PSEL_W   = rfsh_pkg::PSEL_W,
    parameter int DIV_W    = rfsh_pkg::DIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load_i,
    input  logic                cfg_enable_i,
    input  logic [PERIOD_W-1:0] cfg_period_i,
    input  logic [PSEL_W-1:0]   cfg_presc_i,
    input  logic [DIV_W-1:0]    cfg_div_i,
    input  logic [BANK_W-1:0]   cfg_banks_i,
    input  logic                ack_i,
    output logic                req_o,
    output logic [BANK_W-1:0]   req_cs_o,
    output logic                miss_o
);
    import rfsh_pkg::*;

    localparam int PSEL_CAP = PEXP_MAX - 1;

    rfsh_cfg_t        cfg_d, cfg_q;
    logic [EXP_W-1:0] exp_sum;
    logic [EXP_W-1:0] psel_exp;
    logic             tick, expire;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_load_i) begin
            cfg_d.enable = cfg_enable_i;
            cfg_d.period = cfg_period_i;
            cfg_d.presc  = cfg_presc_i;
            cfg_d.div    = cfg_div_i;
            cfg_d.banks  = cfg_banks_i;
        end
        psel_exp = (int'(cfg_q.presc) > PSEL_CAP) ? EXP_W'(PSEL_CAP)
                                                  : EXP_W'(cfg_q.presc);
        exp_sum  = psel_exp + EXP_W'(1) + (EXP_W'(cfg_q.div) << 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    rfsh_prescaler #(.TICK_W(TICK_W), .EXP_W(EXP_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (cfg_load_i),
        .run_i     (cfg_q.enable),
        .exp_i     (exp_sum),
        .tick_o    (tick)
    );

    rfsh_period #(.PERIOD_W(PERIOD_W)) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (cfg_load_i),
        .run_i     (cfg_q.enable),
        .tick_i    (tick),
        .period_i  (cfg_q.period),
        .expire_o  (expire)
    );

    rfsh_rotator #(.BANK_W(BANK_W)) u_rot (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (cfg_load_i),
        .expire_i  (expire),
        .ack_i     (ack_i),
        .banks_i   (cfg_q.banks),
        .req_o     (req_o),
        .cs_o      (req_cs_o),
        .miss_o    (miss_o)
    );

    // R4
    no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.enable |-> !req_o);

    // R8
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_i |=> !req_o && !miss_o);
endmodule

// File: tb/rfsh_timer_test.sv
module rfsh_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load_i = 1'b0;
    logic       cfg_enable_i = 1'b0;
    logic [7:0] cfg_period_i = '0;
    logic [2:0] cfg_presc_i = '0;
    logic [1:0] cfg_div_i = '0;
    logic [2:0] cfg_banks_i = '0;
    logic       ack_i = 1'b0;
    logic       req_o;
    logic [2:0] req_cs_o;
    logic       miss_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rfsh_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load_i),
        .cfg_enable_i(cfg_enable_i), .cfg_period_i(cfg_period_i),
        .cfg_presc_i(cfg_presc_i), .cfg_div_i(cfg_div_i),
        .cfg_banks_i(cfg_banks_i), .ack_i(ack_i), .req_o(req_o),
        .req_cs_o(req_cs_o), .miss_o(miss_o)
    );

    function automatic int div_of(input int ps, input int dv);
        int e = (ps > 5) ? 5 : ps;
        return 1 << (e + 1 + 2 * dv);
    endfunction

    function automatic int per_of(input int p);
        return (p == 0) ? 256 : p;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_load(input bit en, input int per, input int ps,
                           input int dv, input int bk);
        cfg_enable_i = en;
        cfg_period_i = 8'(per);
        cfg_presc_i  = 3'(ps);
        cfg_div_i    = 2'(dv);
        cfg_banks_i  = 3'(bk);
        cfg_load_i   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_load_i   = 1'b0;
    endtask

    task automatic wait_rise(input int limit, output int n);
        n = 0;
        while (!req_o && n < limit) begin
            step(1);
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, tot, dp, nb, hits;
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        check("R1 req", req_o, 0);
        check("R1 miss", miss_o, 0);
        check("R1 cs", req_cs_o, 0);

        // R2 random timing of the first request
        for (int t = 0; t < 8; t++) begin
            int ps = $urandom % 8;
            int dv = $urandom % 2;
            int pr = 1 + $urandom % 12;
            do_load(1'b1, pr, ps, dv, 0);
            wait_rise(20000, n);
            check("R2 first delay", n, div_of(ps, dv) * pr);
        end

        // R3 period 0 means 256
        do_load(1'b1, 0, 0, 0, 0);
        wait_rise(2000, n);
        check("R3 period zero", n, 512);

        // R9 select 7 and 6 clamp to divide by 64
        do_load(1'b1, 2, 7, 0, 0);
        wait_rise(2000, n);
        check("R9 select 7", n, 128);
        do_load(1'b1, 2, 6, 0, 0);
        wait_rise(2000, n);
        check("R9 select 6", n, 128);

        // R4 disabled: never requests
        do_load(1'b0, 1, 0, 0, 0);
        hits = 0;
        for (int i = 0; i < 400; i++) begin
            if (req_o) hits++;
            step(1);
        end
        check("R4 requests while off", hits, 0);

        // R6 R10 R5 rotation, period and acknowledge
        for (int t = 0; t < 3; t++) begin
            nb = $urandom % 8;
            dp = 2 * (3 + $urandom % 4);
            do_load(1'b1, dp / 2, 0, 0, nb);
            tot = 0;
            for (int i = 0; i < nb + 3; i++) begin
                while (!req_o && tot < 5000) begin
                    step(1);
                    tot++;
                end
                check("R10 expiry time", tot, dp * (i + 1));
                check("R6 bank index", req_cs_o, i % (nb + 1));
                ack_i = 1'b1;
                step(1);
                tot++;
                ack_i = 1'b0;
                check("R5 ack clears", req_o, 0);
            end
        end

        // R5 hold without ack
        do_load(1'b1, 3, 0, 0, 3);
        step(6);
        check("R5 rises", req_o, 1);
        step(4);
        check("R5 held", req_o, 1);
        check("R5 cs stable", req_cs_o, 0);
        check("R5 no miss yet", miss_o, 0);

        // R5 ack while idle is ignored
        do_load(1'b1, 3, 0, 0, 3);
        step(2);
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
        wait_rise(100, n);
        check("R5 idle ack timing", n, 3);
        step(3);
        check("R5 idle ack cs", req_cs_o, 0);

        // R7 missed refresh
        do_load(1'b1, 3, 0, 0, 3);
        step(13);
        check("R7 miss set", miss_o, 1);
        check("R7 req kept", req_o, 1);
        check("R7 cs kept", req_cs_o, 0);
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
        check("R7 ack after miss", req_o, 0);
        step(4);
        check("R7 next req", req_o, 1);
        check("R7 no skip", req_cs_o, 1);
        check("R7 miss sticky", miss_o, 1);

        // R8 load clears a pending request and the flag
        do_load(1'b1, 3, 0, 0, 3);
        check("R8 req dropped", req_o, 0);
        check("R8 miss cleared", miss_o, 0);
        wait_rise(100, n);
        check("R8 restart delay", n, 6);
        check("R8 rotation restart", req_cs_o, 0);

        // R7 expiry with ack in the same cycle
        do_load(1'b1, 3, 0, 0, 3);
        step(11);
        ack_i = 1'b1;
        step(1);
        ack_i = 1'b0;
        check("R7 same cycle req", req_o, 1);
        check("R7 same cycle cs", req_cs_o, 1);
        check("R7 same cycle miss", miss_o, 0);

        // R8 reload part way restarts counting
        do_load(1'b1, 5, 1, 0, 0);
        step(18);
        do_load(1'b1, 5, 1, 0, 0);
        wait_rise(200, n);
        check("R8 partial reload", n, 20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule